// File: doc/BRIEF.md
# Doubleword Load Execution Unit

This unit carries out a single 64-bit load for a small in-order core. A start pulse hands it the raw 32-bit instruction word together with the value read from the base register. The unit pulls the destination index, base index and 12-bit offset out of the word and forms the effective address. It checks that the address is aligned to 8 bytes. It then issues one request on a valid/ready memory port that returns 64 bits of data and a fault indication.

The result reaches the register file through a single write port. On a 64-bit core the unit makes one full-width write. On a 32-bit core with register-pair loads enabled, it makes two 32-bit writes on consecutive cycles: the low word goes to the destination register and the high word to the next register.

Illegal use, misalignment and memory-side faults are reported as a cause code and a trap value in place of any write. Two static inputs select the core width and whether pair loads are enabled. Only one instruction is in flight at a time.

Top module: `ldd_unit`

## Requirements
- R1: The offset is instruction bits 31:20, the base index bits 19:15 (driven on `base_sel`) and the destination index bits 11:7. With `cfg_xlen64`=1, the request address is `base_val` plus the offset sign-extended to 64 bits.
- R2: With `cfg_xlen64`=0, the address is the low 32 bits of `base_val` plus the sign-extended offset, wrapping modulo 2^32. Address bits 63:32 are zero.
- R3: With `cfg_xlen64`=1, a load with no fault makes exactly one write of all 64 response bits to the destination register. `done` pulses, with `exc_valid` low, in the cycle after that write.
- R4: With `cfg_xlen64`=0 and `cfg_pair_en`=1, a load with no fault writes response bits 31:0 to the destination register and then, in the next cycle, bits 63:32 to the destination index plus one. Write-data bits 63:32 are zero on both writes. `done` follows the second write.
- R5: With `cfg_xlen64`=0 and `cfg_pair_en`=0, the unit raises cause 2 with the instruction word (zero-extended) as trap value. It issues no memory request and makes no write.
- R6: With `cfg_xlen64`=0 and `cfg_pair_en`=1, an odd destination index raises cause 2. It issues no request and makes no write.
- R7: An effective address whose bits 2:0 are not all zero raises cause 4 with the address as trap value. It issues no request and makes no write. An illegal case takes priority over misalignment.
- R8: A response with `mem_rsp_fault`=1 raises cause 13 if `mem_rsp_page`=1, or cause 5 if it is 0. The trap value is the address, and no write is made.
- R9: A write whose target index is 0 is suppressed (`rf_we` stays low). The other half of a pair is still written.
- R10: `start` is ignored while `busy` is high. The instruction in flight completes unchanged, and no second operation follows it.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with an unchanged address.
- R12: After reset, `busy`, `mem_req_valid`, `rf_we`, `done` and `exc_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_xlen64 | input | 1 | Static: 1 selects a 64-bit core, 0 a 32-bit core |
| cfg_pair_en | input | 1 | Static: enables register-pair loads on a 32-bit core |
| start | input | 1 | Begin a load; taken only when idle |
| instr | input | 32 | Raw instruction word, valid with `start` |
| base_sel | output | 5 | Base register index decoded from `instr` |
| base_val | input | 64 | Base register value, valid with `start` |
| busy | output | 1 | An instruction is in flight |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Request address |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | 64 | Response data |
| mem_rsp_fault | input | 1 | Response carries a fault |
| mem_rsp_page | input | 1 | Fault kind: 1 translation, 0 access |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 64 | Register-file write data |
| done | output | 1 | Completion pulse |
| exc_valid | output | 1 | Completion is an exception (valid with `done`) |
| exc_cause | output | 5 | Exception cause code |
| exc_tval | output | 64 | Trap value: faulting address or instruction word |

## Verification
The hardest situation to reach is a second `start` arriving while the memory port is still holding the request of an earlier load. That second start must not disturb the captured address, destination or later writeback. The bench gets there by keeping `mem_req_ready` low for several cycles and raising `start` with a different instruction during that window. It then checks that exactly one completion follows with the first load's results, and that no second request ever appears. The pair case with destination 0 is also driven: it must drop the low write yet still write the high half.

// File: rtl/ldd_pkg.sv
package ldd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_WLO,
    ST_WHI,
    ST_FIN,
    ST_EXC
  } ldd_state_e;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_ACCESS   = 5'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_PAGE     = 5'd13;
endpackage

// File: rtl/ldd_agen.sv
module ldd_agen #(
  parameter int XW    = 64,
  parameter int IMM_W = 12,
  parameter int AW    = 5,
  parameter int BYTES = 8
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [AW-1:0]    rd,
  input  logic [XW-1:0]    base,
  input  logic             cfg_xlen64,
  input  logic             cfg_pair_en,
  output logic [XW-1:0]    ea,
  output logic             illegal,
  output logic             misaligned
);
  localparam int HW   = XW / 2;
  localparam int LSB  = $clog2(BYTES);

  logic [XW-1:0] offset;
  logic [XW-1:0] sum_full;
  logic [HW-1:0] sum_half;

  always_comb begin
    offset   = {{(XW-IMM_W){imm[IMM_W-1]}}, imm};
    sum_full = base + offset;
    sum_half = base[HW-1:0] + offset[HW-1:0];
    ea       = cfg_xlen64 ? sum_full : {{HW{1'b0}}, sum_half};
    illegal  = !cfg_xlen64 && (!cfg_pair_en || rd[0]);
    misaligned = |ea[LSB-1:0];
  end
endmodule

// File: rtl/ldd_wbsel.sv
module ldd_wbsel #(
  parameter int XW = 64,
  parameter int AW = 5
) (
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          cfg_xlen64,
  input  logic [AW-1:0] rd,
  input  logic [XW-1:0] data,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [XW-1:0] wdata
);
  localparam int HW = XW / 2;

  always_comb begin
    waddr = wr_hi ? {rd[AW-1:1], 1'b1} : rd;
    if (cfg_xlen64)
      wdata = data;
    else if (wr_hi)
      wdata = {{HW{1'b0}}, data[XW-1:HW]};
    else
      wdata = {{HW{1'b0}}, data[HW-1:0]};
    we = (wr_lo || wr_hi) && (waddr != '0);
  end
endmodule

// File: rtl/ldd_unit.sv
module ldd_unit
  import ldd_pkg::*;
#(
  parameter int XW    = 64,
  parameter int IW    = 32,
  parameter int AW    = 5,
  parameter int IMM_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_xlen64,
  input  logic               cfg_pair_en,
  input  logic               start,
  input  logic [IW-1:0]      instr,
  output logic [AW-1:0]      base_sel,
  input  logic [XW-1:0]      base_val,
  output logic               busy,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [XW-1:0]      mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [XW-1:0]      mem_rsp_data,
  input  logic               mem_rsp_fault,
  input  logic               mem_rsp_page,
  output logic               rf_we,
  output logic [AW-1:0]      rf_waddr,
  output logic [XW-1:0]      rf_wdata,
  output logic               done,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XW-1:0]      exc_tval
);
  localparam int RD_LSB  = 7;
  localparam int RS1_LSB = 15;
  localparam int IMM_LSB = IW - IMM_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  ldd_state_e         st_q, st_d;
  logic [AW-1:0]      rd_q;
  logic [XW-1:0]      ea_q, data_q, tval_q, tval_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               cap_en, exc_en, data_en;

  logic [AW-1:0]  dec_rd;
  logic [XW-1:0]  dec_ea;
  logic           dec_ill, dec_mis;

  assign dec_rd   = instr[RD_LSB +: AW];
  assign base_sel = instr[RS1_LSB +: AW];

  ldd_agen #(.XW(XW), .IMM_W(IMM_W), .AW(AW), .BYTES(8)) u_agen (
    .imm        (instr[IMM_LSB +: IMM_W]),
    .rd         (dec_rd),
    .base       (base_val),
    .cfg_xlen64 (cfg_xlen64),
    .cfg_pair_en(cfg_pair_en),
    .ea         (dec_ea),
    .illegal    (dec_ill),
    .misaligned (dec_mis)
  );

  // next-state and capture enables
  always_comb begin
    st_d    = st_q;
    cap_en  = 1'b0;
    exc_en  = 1'b0;
    data_en = 1'b0;
    cause_d = cause_q;
    tval_d  = tval_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        cap_en = 1'b1;
        if (dec_ill) begin
          st_d = ST_EXC; exc_en = 1'b1;
          cause_d = CAUSE_ILLEGAL; tval_d = {{(XW-IW){1'b0}}, instr};
        end else if (dec_mis) begin
          st_d = ST_EXC; exc_en = 1'b1;
          cause_d = CAUSE_MISALIGN; tval_d = dec_ea;
        end else begin
          st_d = ST_REQ;
        end
      end
      ST_REQ: if (mem_req_ready) st_d = ST_RSP;
      ST_RSP: if (mem_rsp_valid) begin
        if (mem_rsp_fault) begin
          st_d = ST_EXC; exc_en = 1'b1;
          cause_d = mem_rsp_page ? CAUSE_PAGE : CAUSE_ACCESS;
          tval_d  = ea_q;
        end else begin
          st_d = ST_WLO; data_en = 1'b1;
        end
      end
      ST_WLO:  st_d = cfg_xlen64 ? ST_FIN : ST_WHI;
      ST_WHI:  st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      ST_EXC:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else if (!rst_ok) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      rd_q <= dec_rd;
      ea_q <= dec_ea;
    end
    if (exc_en) begin
      cause_q <= cause_d;
      tval_q  <= tval_d;
    end
    if (data_en) data_q <= mem_rsp_data;
  end

  ldd_wbsel #(.XW(XW), .AW(AW)) u_wb (
    .wr_lo     (st_q == ST_WLO),
    .wr_hi     (st_q == ST_WHI),
    .cfg_xlen64(cfg_xlen64),
    .rd        (rd_q),
    .data      (data_q),
    .we        (rf_we),
    .waddr     (rf_waddr),
    .wdata     (rf_wdata)
  );

  assign busy          = (st_q != ST_IDLE);
  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_addr  = ea_q;
  assign done          = (st_q == ST_FIN) || (st_q == ST_EXC);
  assign exc_valid     = (st_q == ST_EXC);
  assign exc_cause     = cause_q;
  assign exc_tval      = tval_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  // R5
  no_req_illegal_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_req_valid |-> (cfg_xlen64 || cfg_pair_en));

  // R8
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (st_q == ST_RSP && mem_rsp_valid && mem_rsp_fault) |=> (exc_valid && !rf_we));

  // R9
  no_x0_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rf_we |-> (rf_waddr != '0));

  // R4
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rf_we && !cfg_xlen64 && !rf_waddr[0]) |=> (rf_we && rf_waddr == $past(rf_waddr) + 1'b1));

  // R3
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rf_we && cfg_xlen64) |=> (done && !exc_valid));
endmodule

// File: tb/sim_ldd_unit.sv
module sim_ldd_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        c64;
    logic        pe;
    logic [4:0]  rd;
    logic [11:0] imm;
    logic [63:0] base;
    logic [63:0] data;
    logic        flt;
    logic        pg;
    logic [3:0]  stall;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 5'd5,  12'h010, 64'h1000_0000_0000_1000, 64'h1122_3344_5566_7788, 1'b0, 1'b0, 4'd2}, // R3 R1
    '{1'b1, 1'b0, 5'd31, 12'hFF8, 64'h0000_0000_0000_0100, 64'hDEAD_BEEF_0BAD_F00D, 1'b0, 1'b0, 4'd0}, // R1 negative offset
    '{1'b1, 1'b0, 5'd6,  12'h000, 64'h0000_0000_0000_1004, 64'h0,                   1'b0, 1'b0, 4'd0}, // R7
    '{1'b1, 1'b0, 5'd7,  12'h008, 64'h0000_0000_0000_2000, 64'h5555,                1'b1, 1'b1, 4'd1}, // R8 page
    '{1'b1, 1'b0, 5'd8,  12'h000, 64'h0000_0000_0000_3000, 64'h6666,                1'b1, 1'b0, 4'd0}, // R8 access
    '{1'b0, 1'b1, 5'd10, 12'h010, 64'hABCD_0000_FFFF_FFF8, 64'hCAFE_F00D_1234_5678, 1'b0, 1'b0, 4'd1}, // R4 R2 wrap
    '{1'b0, 1'b0, 5'd12, 12'h000, 64'h0000_0000_0000_0100, 64'h1,                   1'b0, 1'b0, 4'd0}, // R5
    '{1'b0, 1'b1, 5'd7,  12'h000, 64'h0000_0000_0000_0100, 64'h1,                   1'b0, 1'b0, 4'd0}, // R6
    '{1'b1, 1'b0, 5'd0,  12'h000, 64'h0000_0000_0000_0040, 64'h7777_8888_9999_AAAA, 1'b0, 1'b0, 4'd0}, // R9
    '{1'b0, 1'b1, 5'd0,  12'h000, 64'h0000_0000_0000_0080, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, 1'b0, 4'd0}, // R9 pair
    '{1'b0, 1'b1, 5'd4,  12'h004, 64'h0000_0000_0000_0200, 64'h1,                   1'b0, 1'b0, 4'd0}, // R7 32-bit
    '{1'b0, 1'b1, 5'd14, 12'h000, 64'h0000_0000_0000_0300, 64'h1,                   1'b1, 1'b0, 4'd0}  // R8 32-bit
  };

  logic        clk, rst_n, cfg_xlen64, cfg_pair_en, start;
  logic [31:0] instr;
  logic [4:0]  base_sel;
  logic [63:0] base_val;
  logic        busy, mem_req_valid, mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_fault, mem_rsp_page;
  logic [63:0] mem_rsp_data;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [63:0] rf_wdata;
  logic        done, exc_valid;
  logic [4:0]  exc_cause;
  logic [63:0] exc_tval;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  ldd_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_xlen64(cfg_xlen64), .cfg_pair_en(cfg_pair_en),
    .start(start), .instr(instr), .base_sel(base_sel), .base_val(base_val),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_fault(mem_rsp_fault),
    .mem_rsp_page(mem_rsp_page), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .done(done), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .exc_tval(exc_tval)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [11:0] imm, input logic [4:0] rs1, input logic [4:0] rd);
    return {imm, rs1, 3'b011, rd, 7'b0000011};
  endfunction

  function automatic string vtag(input int i);
    case (i)
      0: return "R3";  1: return "R1";  2: return "R7";  3: return "R8";
      4: return "R8";  5: return "R4";  6: return "R5";  7: return "R6";
      8: return "R9";  9: return "R9";  10: return "R7"; default: return "R8";
    endcase
  endfunction

  // observed results of one operation
  int          n_req, n_wr;
  logic [63:0] req_addr;
  logic [4:0]  wr_a [2];
  logic [63:0] wr_d [2];
  logic        got_done, got_exc, addr_moved;
  logic [4:0]  got_cause;
  logic [63:0] got_tval;

  task automatic run_op(input vec_t v, input logic [31:0] iw, input logic inject);
    int   st;
    logic hs;
    n_req = 0; n_wr = 0; got_done = 0; got_exc = 0; addr_moved = 0;
    req_addr = '0; got_cause = '0; got_tval = '0;
    st = int'(v.stall); hs = 0;
    @(negedge clk);
    cfg_xlen64 = v.c64; cfg_pair_en = v.pe;
    start = 1'b1; instr = iw; base_val = v.base;
    @(negedge clk);
    start = 1'b0;
    instr = 32'h0; base_val = 64'hFFFF_FFFF_FFFF_FFF0;
    for (int k = 0; k < 60; k++) begin
      if (inject && k == 1) begin
        start = 1'b1; instr = enc(12'h000, 5'd3, 5'd20); base_val = 64'h8000;
      end else begin
        start = 1'b0;
      end
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (hs) begin
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b1;
        mem_rsp_data = v.data; mem_rsp_fault = v.flt; mem_rsp_page = v.pg;
        hs = 0;
      end
      if (rf_we) begin
        if (n_wr < 2) begin wr_a[n_wr] = rf_waddr; wr_d[n_wr] = rf_wdata; end
        n_wr++;
      end
      if (done) begin
        got_done = 1; got_exc = exc_valid; got_cause = exc_cause; got_tval = exc_tval;
        break;
      end
      if (mem_req_valid) begin
        if (n_req == 0) begin n_req = 1; req_addr = mem_req_addr; end
        else if (mem_req_addr != req_addr) addr_moved = 1;
        if (st > 0) st--;
        else begin mem_req_ready = 1'b1; hs = 1; end
      end
      @(negedge clk);
    end
    start = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
  endtask

  task automatic check_vec(input int i, input vec_t v, input logic [31:0] iw);
    logic [63:0] sx, ea, tval;
    logic        ill, mis, exp_req;
    logic [4:0]  cause;
    int          nw;
    logic [4:0]  ea_a [2];
    logic [63:0] ea_d [2];
    string       t;
    t = vtag(i);
    sx = {{52{v.imm[11]}}, v.imm};
    ea = v.c64 ? v.base + sx : {32'h0, v.base[31:0] + sx[31:0]};
    ill = !v.c64 && (!v.pe || v.rd[0]);
    mis = (ea[2:0] != 3'b000);
    exp_req = !ill && !mis;
    cause = ill ? 5'd2 : mis ? 5'd4 : v.flt ? (v.pg ? 5'd13 : 5'd5) : 5'd0;
    tval  = ill ? {32'h0, iw} : ea;
    nw = 0;
    ea_a[0] = '0; ea_a[1] = '0; ea_d[0] = '0; ea_d[1] = '0;
    if (cause == 5'd0) begin
      if (v.c64) begin
        if (v.rd != 5'd0) begin ea_a[0] = v.rd; ea_d[0] = v.data; nw = 1; end
      end else begin
        if (v.rd != 5'd0) begin ea_a[nw] = v.rd; ea_d[nw] = {32'h0, v.data[31:0]}; nw++; end
        ea_a[nw] = v.rd + 5'd1; ea_d[nw] = {32'h0, v.data[63:32]}; nw++;
      end
    end
    check(t, "done seen", 64'(got_done), 64'd1);
    check(t, "exception flag", 64'(got_exc), 64'(cause != 5'd0));
    if (cause != 5'd0) begin
      check(t, "cause", 64'(got_cause), 64'(cause));
      check(t, "trap value", got_tval, tval);
    end
    check(t, "request count", 64'(n_req), 64'(exp_req));
    if (exp_req) begin
      check(v.c64 ? "R1" : "R2", "request address", req_addr, ea);
      check("R11", "address held during stall", 64'(addr_moved), 64'd0);
    end
    check(t, "write count", 64'(n_wr), 64'(nw));
    for (int w = 0; w < nw && w < n_wr && w < 2; w++) begin
      check(t, "write index", 64'(wr_a[w]), 64'(ea_a[w]));
      check(t, "write data", wr_d[w], ea_d[w]);
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_xlen64 = 1'b1; cfg_pair_en = 1'b0; start = 1'b0;
    instr = '0; base_val = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    mem_rsp_data = '0; mem_rsp_fault = 1'b0; mem_rsp_page = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12", "busy", 64'(busy), 64'd0);
    check("R12", "request valid", 64'(mem_req_valid), 64'd0);
    check("R12", "write enable", 64'(rf_we), 64'd0);
    check("R12", "done", 64'(done), 64'd0);
    check("R12", "exception", 64'(exc_valid), 64'd0);

    // R1 base index field
    instr = enc(12'h000, 5'd19, 5'd2);
    #1;
    check("R1", "base index", 64'(base_sel), 64'd19);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] iw;
      iw = enc(VECS[i].imm, 5'd9, VECS[i].rd);
      run_op(VECS[i], iw, 1'b0);
      check_vec(i, VECS[i], iw);
    end

    // R10 start while busy: held in REQ by a stall, second start injected
    begin
      vec_t v;
      logic [31:0] iw;
      v = '{1'b1, 1'b0, 5'd17, 12'h020, 64'h0000_0000_0000_4000, 64'h0F0E_0D0C_0B0A_0908, 1'b0, 1'b0, 4'd4};
      iw = enc(v.imm, 5'd9, v.rd);
      run_op(v, iw, 1'b1);
      check("R10", "request address kept", req_addr, 64'h4020);
      check("R10", "write count", 64'(n_wr), 64'd1);
      check("R10", "write index kept", 64'(wr_a[0]), 64'd17);
      check("R10", "write data", wr_d[0], v.data);
      begin
        int extra;
        extra = 0;
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          if (mem_req_valid || busy || done) extra++;
        end
        check("R10", "no second operation", 64'(extra), 64'd0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule